// File: doc/BRIEF.md
# Forward/Reverse Subtractor

This block subtracts one unsigned operand from another. A single direction bit decides which operand is the minuend. With the bit low it produces `A - B`. With the bit high it produces `B - A`. The result wraps modulo 2^W, as in two's complement arithmetic.

Both directions share one adder:

- A row of XOR gates, driven by the direction bit, ones'-complements whichever operand is being subtracted.
- The carry-in is tied to 1, which completes the two's complement of that operand.
- The carries come from a radix-four parallel-prefix network rather than a ripple chain. Per-bit generate/propagate pairs are merged four at a time into nibble groups. Nibble groups are merged four at a time into 16-bit groups.

The carry-out is exported. It is high exactly when the minuend is not smaller than the subtrahend, so a loop that keeps reducing the larger of two numbers can steer itself from it. An optional output register, on by default, holds the difference and the carry-out for one clock.

Top module: `fwdrev_sub`

## Requirements
- R1: With `dir` = 0, `diff` equals (`opa` - `opb`) modulo 2^W.
- R2: With `dir` = 1, `diff` equals (`opb` - `opa`) modulo 2^W.
- R3: `borrow_n` is 1 exactly when the minuend is greater than or equal to the subtrahend. The minuend is `opa` for `dir` = 0 and `opb` for `dir` = 1.
- R4: When `opa` equals `opb`, `diff` is 0 and `borrow_n` is 1, whatever the value of `dir`.
- R5: With the output register enabled (default `REG_OUT` = 1), the result of the operands and `dir` present at a rising clock edge appears on `diff`/`borrow_n` right after that edge. The outputs do not move between edges.
- R6: While `rst_n` is low, `diff` is 0 and `borrow_n` is 0 whatever the inputs.
- R7: A zero subtrahend gives the minuend itself with `borrow_n` = 1. A zero minuend with a nonzero subtrahend gives the two's complement of the subtrahend with `borrow_n` = 0.
- R8: Carries that cross every nibble and 16-bit group boundary resolve correctly. For example, 0x1000 - 0x0001 = 0x0FFF, and 0x0000 - 0x0001 = 0xFFFF with `borrow_n` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| dir | input | 1 | 0: opa - opb, 1: opb - opa |
| opa | input | W (16) | Operand A, unsigned |
| opb | input | W (16) | Operand B, unsigned |
| diff | output | W (16) | Difference modulo 2^W |
| borrow_n | output | 1 | Carry-out; 1 when no borrow occurred |

## Verification
A wrong generate, propagate or group term in the prefix network shows at the ports as a wrong `diff` bit. It also shows on `borrow_n` when the error sits on the carry path into the top group. With the default register, either appears one clock after the operands are captured. The errors only surface for operand pairs whose carries run through the faulty group, so long random runs in both directions are combined with directed vectors. Those directed vectors push a carry across every nibble boundary, and across zero and equal operands. Inside the prefix network, each nibble's bit-level carry-out is compared against the group-level carry into the next nibble in the same cycle.

// File: rtl/fwdrev_sub_pkg.sv
package fwdrev_sub_pkg;

  // Carries into the four positions of a radix-four group, given per-position
  // generate/propagate and the carry entering the group (position 0 gets ci).
  function automatic logic [3:0] la4_carries(input logic [3:0] g,
                                             input logic [3:0] p,
                                             input logic       ci);
    logic [3:0] c;
    c[0] = ci;
    c[1] = g[0] | (p[0] & ci);
    c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & ci);
    c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & ci);
    return c;
  endfunction

  // Group generate of four merged positions.
  function automatic logic la4_gen(input logic [3:0] g, input logic [3:0] p);
    return g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]);
  endfunction

  // Group propagate of four merged positions.
  function automatic logic la4_prop(input logic [3:0] p);
    return &p;
  endfunction

endpackage

// File: rtl/fwdrev_sub_invert.sv
module fwdrev_sub_invert #(
  parameter int W = 16
) (
  input  logic         dir,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] xa,
  output logic [W-1:0] xb
);
  // The subtracted operand is ones'-complemented; the other passes through.
  assign xa = opa ^ {W{dir}};
  assign xb = opb ^ {W{~dir}};
endmodule

// File: rtl/fwdrev_sub_prefix.sv
module fwdrev_sub_prefix
  import fwdrev_sub_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] g,
  input  logic [W-1:0] p,
  input  logic         cin,
  output logic [W:0]   carry
);
  localparam int NIB = W / 4;
  localparam int NSG = NIB / 4;

  logic [NIB-1:0] nib_g;
  logic [NIB-1:0] nib_p;
  logic [NIB-1:0] nib_cin;
  logic [NSG-1:0] sg_g;
  logic [NSG-1:0] sg_p;
  logic [NSG:0]   sg_cin;

  // Level 1: merge bits four at a time into nibble groups.
  for (genvar n = 0; n < NIB; n++) begin : g_nib
    assign nib_g[n] = la4_gen(g[4*n +: 4], p[4*n +: 4]);
    assign nib_p[n] = la4_prop(p[4*n +: 4]);
  end

  // Level 2: merge nibbles four at a time into 16-bit groups.
  for (genvar s = 0; s < NSG; s++) begin : g_sg
    assign sg_g[s] = la4_gen(nib_g[4*s +: 4], nib_p[4*s +: 4]);
    assign sg_p[s] = la4_prop(nib_p[4*s +: 4]);
    assign sg_cin[s+1] = sg_g[s] | (sg_p[s] & sg_cin[s]);
    assign nib_cin[4*s +: 4] = la4_carries(nib_g[4*s +: 4], nib_p[4*s +: 4], sg_cin[s]);
  end
  assign sg_cin[0] = cin;

  // Distribute group carries back down to every bit.
  for (genvar n = 0; n < NIB; n++) begin : g_bit
    assign carry[4*n +: 4] = la4_carries(g[4*n +: 4], p[4*n +: 4], nib_cin[n]);
  end
  assign carry[W] = sg_cin[NSG];

  // R8: bit-level carry out of each nibble must match the group-level carry
  // delivered to the next nibble (two separately built paths).
  for (genvar n = 0; n < NIB - 1; n++) begin : g_chk
    logic nib_out_bit;
    assign nib_out_bit = g[4*n+3] | (p[4*n+3] & carry[4*n+3]);
    always_comb begin
      if (!$isunknown({g, p, cin}))
        a_r8_nibble_carry : assert (nib_out_bit == nib_cin[n+1]);
    end
  end

  always_comb begin
    if (!$isunknown({g, p, cin}))
      a_r8_top_carry : assert ((g[W-1] | (p[W-1] & carry[W-1])) == carry[W]);
  end
endmodule

// File: rtl/fwdrev_sub.sv
module fwdrev_sub #(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] diff,
  output logic         borrow_n
);
  logic [W-1:0] xa, xb;
  logic [W-1:0] gen_b, prop_b;
  logic [W:0]   carry;
  logic [W-1:0] sum_c;
  logic         cout_c;

  fwdrev_sub_invert #(.W(W)) u_inv (
    .dir(dir), .opa(opa), .opb(opb), .xa(xa), .xb(xb)
  );

  assign gen_b  = xa & xb;
  assign prop_b = xa ^ xb;

  // Carry-in of 1 completes the two's complement of the inverted operand.
  fwdrev_sub_prefix #(.W(W)) u_pfx (
    .g(gen_b), .p(prop_b), .cin(1'b1), .carry(carry)
  );

  assign sum_c  = prop_b ^ carry[W-1:0];
  assign cout_c = carry[W];

  if (REG_OUT) begin : g_reg
    logic [W-1:0] diff_q;
    logic         cout_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        diff_q <= '0;
        cout_q <= 1'b0;
      end else begin
        diff_q <= sum_c;
        cout_q <= cout_c;
      end
    end
    assign diff     = diff_q;
    assign borrow_n = cout_q;

    // Checks against the arithmetic operator, one cycle after capture.
    logic armed;
    always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
    end

    a_r1_forward : assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(dir)) |-> diff == W'($past(opa) - $past(opb)));
    a_r2_reverse : assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(dir)) |-> diff == W'($past(opb) - $past(opa)));
    a_r3_carry_out : assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> borrow_n == ($past(dir) ? ($past(opb) >= $past(opa))
                                        : ($past(opa) >= $past(opb))));
    a_r4_equal_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(opa) == $past(opb)) |-> (diff == '0 && borrow_n));
    a_r6_reset_clear : assert property (@(posedge clk)
      $past(!rst_n) |-> (diff == '0 && !borrow_n));
  end else begin : g_comb
    assign diff     = sum_c;
    assign borrow_n = cout_c;
  end
endmodule

// File: tb/sim_fwdrev_sub.sv
module sim_fwdrev_sub;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dir = 1'b0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic [W-1:0] diff;
  logic         borrow_n;

  fwdrev_sub #(.W(W), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .dir(dir), .opa(opa), .opb(opb),
    .diff(diff), .borrow_n(borrow_n)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [W-1:0] d;
    logic         c;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  // Driver: applies one vector on the falling edge and queues its expectation.
  task automatic drive(input logic s, input logic [W-1:0] a, input logic [W-1:0] b,
                       input string tag);
    logic [W:0] t;
    exp_t e;
    @(negedge clk);
    dir = s; opa = a; opb = b;
    t = s ? ({1'b0, b} - {1'b0, a}) : ({1'b0, a} - {1'b0, b});
    e.d = t[W-1:0];
    e.c = ~t[W];
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: the vector driven before a rising edge is visible just after it.
  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_tests++;
      if (diff !== e.d) begin
        n_fail++;
        $display("FAIL %s diff: actual %h expected %h", e.tag, diff, e.d);
      end
      n_tests++;
      if (borrow_n !== e.c) begin
        n_fail++;
        $display("FAIL R3 (%s) borrow_n: actual %b expected %b", e.tag, borrow_n, e.c);
      end
    end
  end

  initial begin
    // R6: outputs held clear during reset despite nonzero inputs.
    dir = 1'b0; opa = 16'h1234; opb = 16'h0001;
    repeat (3) @(posedge clk);
    #1;
    n_tests++;
    if (diff !== '0 || borrow_n !== 1'b0) begin
      n_fail++;
      $display("FAIL R6 reset: actual %h/%b expected 0000/0", diff, borrow_n);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R4: equal operands, both directions.
    drive(1'b0, 16'h5A5A, 16'h5A5A, "R4");
    drive(1'b1, 16'hFFFF, 16'hFFFF, "R4");
    drive(1'b0, 16'h0000, 16'h0000, "R4");
    // R7: zero operands.
    drive(1'b0, 16'hBEEF, 16'h0000, "R7");
    drive(1'b1, 16'h0000, 16'hBEEF, "R7");
    drive(1'b0, 16'h0000, 16'h0123, "R7");
    drive(1'b1, 16'h0123, 16'h0000, "R7");
    // R8: carries across nibble and group boundaries.
    drive(1'b0, 16'h1000, 16'h0001, "R8");
    drive(1'b1, 16'h0001, 16'h1000, "R8");
    drive(1'b0, 16'h0000, 16'h0001, "R8");
    drive(1'b0, 16'h8000, 16'h7FFF, "R8");
    drive(1'b1, 16'h00F0, 16'h0100, "R8");
    // R1/R2/R3: fixed example pairs.
    drive(1'b0, 16'd65523, 16'd43682, "R1");
    drive(1'b1, 16'd28657, 16'd46368, "R2");

    // R5: outputs stay put between edges, then change right after the edge.
    drive(1'b0, 16'h0010, 16'h0001, "R5");
    @(posedge clk); #2;
    @(negedge clk);
    dir = 1'b0; opa = 16'h0100; opb = 16'h0001;
    #1;
    n_tests++;
    if (diff !== 16'h000F) begin
      n_fail++;
      $display("FAIL R5 hold before edge: actual %h expected 000f", diff);
    end
    @(posedge clk); #2;
    n_tests++;
    if (diff !== 16'h00FF) begin
      n_fail++;
      $display("FAIL R5 after edge: actual %h expected 00ff", diff);
    end

    // R1/R2/R3: random vectors in both directions.
    for (int i = 0; i < 3000; i++) begin
      logic s;
      s = i[0];
      drive(s, W'($urandom), W'($urandom), s ? "R2" : "R1");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule